// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page by reading two table entries from main memory. A client hands it a virtual address and the byte address of the root table. The walker splits the address into an upper 10-bit index, a middle 10-bit index and a 12-bit page offset. It fetches the root entry, which gives the base of a second-level table. It then fetches the leaf entry from that table. Each entry is one 32-bit word, and a 1024-entry table fills one 4 KB page.

The outcome is reported with a one-cycle `done` pulse. A successful walk returns the real page number, the dirty flag, the access permissions and the 26-bit physical address. A walk that meets a cleared valid bit at either level returns a fault instead and issues no further reads. The memory port carries one outstanding word read at a time. A read is a one-cycle request pulse, and its answer may come back any number of cycles later, but no sooner than the cycle after the request.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: One cycle after a request is accepted, `mem_req_valid` pulses for exactly one cycle. Its address is the root base plus four times VA bits 31:22.
- R3: When the root entry arrives with bit 0 (valid) set, a second read is pulsed in the next cycle. Its address is the root entry's bits 31:12 followed by twelve zero bits, plus four times VA bits 21:12.
- R4: On a successful walk, the fields are taken from the leaf entry: `rpn` from bits 25:12, `perm` from bits 4:2 and `dirty` from bit 1, while bit 0 is the valid flag. `fault` is 0.
- R5: On a successful walk, `pa` is `rpn` joined above VA bits 11:0.
- R6: A root entry with bit 0 clear ends the walk with `fault`=1 in the cycle after its arrival, and no second read is issued.
- R7: A leaf entry with bit 0 clear ends the walk with `fault`=1. On any fault, `rpn`, `perm`, `dirty` and `pa` are zero.
- R8: `done` is high for exactly one cycle, and that cycle is the one after the response that ends the walk.
- R9: `req_ready` is 1 only when idle. A request presented while a walk is in progress, including the `done` cycle, is ignored and does not alter the walk in flight.
- R10: A memory response arriving in a cycle where no read is awaited (the request cycle itself) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle; a request is taken on this cycle |
| req_va | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the root table |
| mem_req_valid | output | 1 | One-cycle word-read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk hit an invalid entry |
| rpn | output | 14 | Real page number |
| perm | output | 3 | Access-permission bits |
| dirty | output | 1 | Dirty flag of the page |
| pa | output | 26 | Physical address |

## Verification
Two things can land in the same cycle: the completion pulse and a fresh request from a client that has not yet seen `done`. The bench raises `req_valid` in the `done` cycle and judges the result by checking that no read appears in the following cycle. A read response can also collide with the request cycle of the walker. The bench places a corrupted response in the very cycle the read is issued, then checks that the addresses and results follow only the response that comes later. Random walks with random latencies and random entry contents, together with busy-time requests, cover the rest.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    PTW_IDLE = 3'd0,
    PTW_RD1  = 3'd1,
    PTW_WT1  = 3'd2,
    PTW_RD2  = 3'd3,
    PTW_WT2  = 3'd4,
    PTW_DONE = 3'd5
  } ptw_state_e;

  // field positions inside a table entry word
  localparam int unsigned ENT_VALID_BIT = 0;
  localparam int unsigned ENT_DIRTY_BIT = 1;
  localparam int unsigned ENT_PERM_LSB  = 2;
  localparam int unsigned ENT_RPN_LSB   = 12;
  localparam int unsigned ENT_SHIFT     = 2;  // log2 of entry size in bytes
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       rsp_valid,
  input  logic       ent_valid,
  output ptw_state_e state_q,
  output logic       ld_req,
  output logic       ld_root,
  output logic       ld_res
);
  ptw_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PTW_IDLE: if (req_valid) state_d = PTW_RD1;
      PTW_RD1:  state_d = PTW_WT1;
      PTW_WT1:  if (rsp_valid) state_d = ent_valid ? PTW_RD2 : PTW_DONE;
      PTW_RD2:  state_d = PTW_WT2;
      PTW_WT2:  if (rsp_valid) state_d = PTW_DONE;
      PTW_DONE: state_d = PTW_IDLE;
      default:  state_d = PTW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PTW_IDLE;
    else        state_q <= state_d;
  end

  assign ld_req  = (state_q == PTW_IDLE) && req_valid;
  assign ld_root = (state_q == PTW_WT1) && rsp_valid && ent_valid;
  assign ld_res  = ((state_q == PTW_WT1) && rsp_valid && !ent_valid) ||
                   ((state_q == PTW_WT2) && rsp_valid);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX1_W   = 10,
  parameter int unsigned IDX2_W   = 10,
  parameter int unsigned OFF_W    = 12
) (
  input  ptw_state_e          state,
  input  logic [ADDR_W-1:0]   va,
  input  logic [ADDR_W-1:0]   root_base,
  input  logic [ADDR_W-1:0]   leaf_base,
  output logic [ADDR_W-1:0]   rd_addr
);
  localparam int unsigned PAD1 = ADDR_W - IDX1_W - ENT_SHIFT;
  localparam int unsigned PAD2 = ADDR_W - IDX2_W - ENT_SHIFT;

  logic [IDX1_W-1:0] idx1;
  logic [IDX2_W-1:0] idx2;
  logic [ADDR_W-1:0] off1;
  logic [ADDR_W-1:0] off2;

  assign idx1 = va[ADDR_W-1 -: IDX1_W];
  assign idx2 = va[OFF_W +: IDX2_W];
  assign off1 = {{PAD1{1'b0}}, idx1, {ENT_SHIFT{1'b0}}};
  assign off2 = {{PAD2{1'b0}}, idx2, {ENT_SHIFT{1'b0}}};

  always_comb begin
    if (state == PTW_RD2) rd_addr = leaf_base + off2;
    else                  rd_addr = root_base + off1;
  end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned RPN_W  = 14,
  parameter int unsigned PERM_W = 3
) (
  input  logic [ADDR_W-1:0] word,
  output logic              valid,
  output logic              dirty,
  output logic [PERM_W-1:0] perm,
  output logic [RPN_W-1:0]  rpn,
  output logic [ADDR_W-1:0] next_base
);
  assign valid     = word[ENT_VALID_BIT];
  assign dirty     = word[ENT_DIRTY_BIT];
  assign perm      = word[ENT_PERM_LSB +: PERM_W];
  assign rpn       = word[ENT_RPN_LSB +: RPN_W];
  assign next_base = {word[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX1_W = 10,
  parameter int unsigned IDX2_W = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned RPN_W  = 14,
  parameter int unsigned PERM_W = 3,
  localparam int unsigned PA_W  = RPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] req_root,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [RPN_W-1:0]  rpn,
  output logic [PERM_W-1:0] perm,
  output logic              dirty,
  output logic [PA_W-1:0]   pa
);
  logic              rst_sync_n;
  ptw_state_e        state_q;
  logic              ld_req, ld_root, ld_res;
  logic              ent_valid, ent_dirty;
  logic [PERM_W-1:0] ent_perm;
  logic [RPN_W-1:0]  ent_rpn;
  logic [ADDR_W-1:0] ent_base;

  logic [ADDR_W-1:0] va_q, root_q, leaf_q;
  logic              fault_q, dirty_q;
  logic [PERM_W-1:0] perm_q;
  logic [RPN_W-1:0]  rpn_q;

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .rsp_valid (mem_rsp_valid),
    .ent_valid (ent_valid),
    .state_q   (state_q),
    .ld_req    (ld_req),
    .ld_root   (ld_root),
    .ld_res    (ld_res)
  );

  ptw_entry_decode #(
    .ADDR_W (ADDR_W), .OFF_W (OFF_W), .RPN_W (RPN_W), .PERM_W (PERM_W)
  ) u_dec (
    .word      (mem_rsp_data),
    .valid     (ent_valid),
    .dirty     (ent_dirty),
    .perm      (ent_perm),
    .rpn       (ent_rpn),
    .next_base (ent_base)
  );

  ptw_addr_gen #(
    .ADDR_W (ADDR_W), .IDX1_W (IDX1_W), .IDX2_W (IDX2_W), .OFF_W (OFF_W)
  ) u_agen (
    .state     (state_q),
    .va        (va_q),
    .root_base (root_q),
    .leaf_base (leaf_q),
    .rd_addr   (mem_req_addr)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (ld_req) begin
      va_q   <= req_va;
      root_q <= req_root;
    end
  end

  // second-level table base
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  leaf_q <= '0;
    else if (ld_root) leaf_q <= ent_base;
  end

  // result capture; all fields cleared on a fault
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_q <= 1'b0;
      dirty_q <= 1'b0;
      perm_q  <= '0;
      rpn_q   <= '0;
    end else if (ld_res) begin
      fault_q <= !ent_valid;
      dirty_q <= ent_valid & ent_dirty;
      perm_q  <= ent_valid ? ent_perm : '0;
      rpn_q   <= ent_valid ? ent_rpn  : '0;
    end
  end

  assign req_ready     = (state_q == PTW_IDLE);
  assign mem_req_valid = (state_q == PTW_RD1) || (state_q == PTW_RD2);
  assign done          = (state_q == PTW_DONE);
  assign fault         = fault_q;
  assign rpn           = rpn_q;
  assign perm          = perm_q;
  assign dirty         = dirty_q;
  assign pa            = fault_q ? '0 : {rpn_q, va_q[OFF_W-1:0]};
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva #(
  parameter int unsigned RPN_W  = 14,
  parameter int unsigned PERM_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic [RPN_W-1:0]  rpn,
  input logic [PERM_W-1:0] perm,
  input logic              dirty
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done);

  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req_valid);

  a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (rpn == '0) && (perm == '0) && !dirty);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind pt_walker pt_walker_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .rpn           (rpn),
  .perm          (perm),
  .dirty         (dirty)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_root = '0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault, dirty;
  logic [13:0] rpn;
  logic [2:0]  perm;
  logic [25:0] pa;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  pt_walker u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_va (req_va), .req_root (req_root),
    .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
    .done (done), .fault (fault), .rpn (rpn), .perm (perm),
    .dirty (dirty), .pa (pa)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_l1(input logic [31:0] va, input logic [31:0] root);
    return root + {20'd0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] addr_l2(input logic [31:0] va, input logic [31:0] ent);
    return {ent[31:12], 12'd0} + {20'd0, va[21:12], 2'b00};
  endfunction

  task automatic wait_rsp(input int lat, input bit busy, input logic [31:0] va,
                          input logic [31:0] data);
    for (int i = 0; i < lat - 1; i++) begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin req_valid = 1'b1; req_va = ~va; end
      chk(req_ready == 1'b0, "R9 busy ready", 32'(req_ready), 32'd0);
      chk(mem_req_valid == 1'b0 && done == 1'b0, "R2 no extra read", 32'(mem_req_valid), 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic do_walk(input logic [31:0] va, input logic [31:0] root,
                         input logic [31:0] e1, input logic [31:0] e2,
                         input int lat1, input int lat2, input bit stray, input bit busy);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_va = va; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_req_valid == 1'b1, "R2 first read strobe", 32'(mem_req_valid), 32'd1);
    chk(mem_req_addr == addr_l1(va, root), "R2 first read addr", mem_req_addr, addr_l1(va, root));
    if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_data = ~e1; end  // R10
    wait_rsp(lat1, busy, va, e1);
    if (!e1[0]) begin
      chk(done == 1'b1 && fault == 1'b1, "R6 fault on root entry", {done, fault}, 32'd3);
      chk(mem_req_valid == 1'b0, "R6 no second read", 32'(mem_req_valid), 32'd0);
      chk(rpn == '0 && perm == '0 && !dirty && pa == '0, "R7 fault fields zero",
          32'(pa), 32'd0);
    end else begin
      chk(mem_req_valid == 1'b1, "R3 second read strobe", 32'(mem_req_valid), 32'd1);
      chk(mem_req_addr == addr_l2(va, e1), "R3 second read addr", mem_req_addr, addr_l2(va, e1));
      if (stray) begin mem_rsp_valid = 1'b1; mem_rsp_data = ~e2; end  // R10
      wait_rsp(lat2, busy, va, e2);
      chk(done == 1'b1, "R8 done after leaf", 32'(done), 32'd1);
      chk(fault == !e2[0], "R7 leaf fault flag", 32'(fault), 32'(!e2[0]));
      if (e2[0]) begin
        chk(rpn == e2[25:12], "R4 rpn field", 32'(rpn), 32'(e2[25:12]));
        chk(perm == e2[4:2] && dirty == e2[1], "R4 perm dirty",
            {perm, dirty}, {e2[4:2], e2[1]});
        chk(pa == {e2[25:12], va[11:0]}, "R5 physical address", 32'(pa),
            32'({e2[25:12], va[11:0]}));
      end else begin
        chk(rpn == '0 && perm == '0 && !dirty && pa == '0, "R7 fault fields zero",
            32'(pa), 32'd0);
      end
    end
    if (busy) begin req_valid = 1'b1; req_va = ~va; end  // coincides with done
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
    chk(mem_req_valid == 1'b0 && req_ready == 1'b1, "R9 request in done cycle ignored",
        {mem_req_valid, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1 reset state",
        {req_ready, done, mem_req_valid}, 32'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1 idle after reset",
        {req_ready, done, mem_req_valid}, 32'd4);

    // directed corners
    do_walk(32'h0000_0000, 32'h0000_1000, 32'h0000_2001, 32'h03FF_F01F, 1, 1, 0, 0);
    do_walk(32'hFFFF_FFFF, 32'h0010_0000, 32'hFFFF_F001, 32'h03FF_F003, 2, 3, 0, 0);
    do_walk(32'h1234_5678, 32'h0000_4000, 32'h0000_8000, 32'h0000_0000, 1, 1, 0, 0);
    do_walk(32'h8765_4321, 32'h0000_4000, 32'h0000_9001, 32'h0123_4FFE, 3, 1, 0, 0);
    do_walk(32'hABCD_E123, 32'h0003_0000, 32'h0005_0001, 32'h0155_5015, 2, 2, 1, 0);
    do_walk(32'h0F0F_0F0F, 32'h0004_0000, 32'h0006_0001, 32'h02AA_A009, 3, 2, 0, 1);

    // random walks
    for (int n = 0; n < 300; n++) begin
      logic [31:0] va, root, e1, e2;
      va   = $urandom;
      root = {$urandom_range(0, 32'h000F_FFFF), 12'd0};
      e1   = $urandom;
      e1[0] = ($urandom_range(0, 7) != 0);
      e2   = $urandom;
      e2[0] = ($urandom_range(0, 7) != 0);
      do_walk(va, root, e1, e2, $urandom_range(1, 4), $urandom_range(1, 4),
              $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule